// File: doc/BRIEF.md
# SCL Clock Generator with Wired-AND Synchronization

This block produces the serial clock of a two-wire bus master. It never drives the line high. It either pulls SCL low or lets it float, so other masters and slaves on the wired-AND line can hold the clock low. Two programmable counts, both measured in system-clock cycles, set the length of the phase in which the block pulls SCL low and the length of the phase in which it leaves SCL released.

The low phase is timed only by the block's own counter. When that count ends, the block releases the line and waits for as long as the bus stays low. This wait has no limit, so a slave that stretches the clock simply holds the block in it. The high count begins only once the synchronized bus level reads high. It ends early if any other device pulls the line low, and the block then starts a new low phase. As a result, the low time seen on the bus is the longest low time among the devices, and the high time is the shortest high time.

Two single-cycle strobes tell a separate data engine where the bit boundaries are: one where the bus is seen to rise and one where the block drives it low. The strobes have no handshake. The data engine must accept each strobe in the cycle it is asserted. START/STOP sequencing and byte handling belong to other blocks.

Top module: `scl_clock_sync`

## Requirements
- R1: While `rst_n` is low or `enable` is low, `scl_drive_low`, `sample_stb` and `shift_stb` are 0 from the next clock edge onward. Both phase counters are cleared, so the first low phase after enabling has its full programmed length.
- R2: Each low phase holds `scl_drive_low` at 1 for exactly max(`low_div`, SYNC_STAGES+1) cycles. Values of `low_div` below 3 therefore give 3 cycles at the default depth.
- R3: After its low count, the block sets `scl_drive_low` to 0. It then stays released and issues no `sample_stb` for as long as the synchronized SCL reads low, with no timeout.
- R4: `scl_in` passes through a SYNC_STAGES-flop synchronizer that resets to 1. On a free bus, the released period lasts SYNC_STAGES+1 cycles of waiting plus max(`high_div`, 1) cycles of high count. The block then pulls SCL low again.
- R5: If the synchronized SCL reads low during the high count, the block abandons that count. It pulls SCL low in the following cycle, which is SYNC_STAGES+1 cycles after the bus went low.
- R6: If another device keeps SCL low for S cycles past the end of the block's own low count, the released period grows by exactly S cycles.
- R7: `shift_stb` is high for exactly one cycle: the first cycle of each low phase, i.e. the cycle in which `scl_drive_low` rises.
- R8: `sample_stb` is high for exactly one cycle per high phase: the first cycle of the high count, which is SYNC_STAGES+1 cycles after the bus is seen to rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the clock when 1; release SCL and idle when 0 |
| low_div | input | CNT_W | Low-phase length in system cycles (minimum SYNC_STAGES+1) |
| high_div | input | CNT_W | High-phase length in system cycles (minimum 1) |
| scl_in | input | 1 | Raw SCL level read back from the bus |
| scl_drive_low | output | 1 | 1 pulls SCL low (open-drain enable), 0 releases it |
| sample_stb | output | 1 | One-cycle pulse at the observed SCL rise |
| shift_stb | output | 1 | One-cycle pulse when the block drives SCL low |

## Verification
A wrong phase state or counter value shows up at the ports within one SCL period. A wrong value makes a low phase or a released period the wrong length, or it moves `sample_stb` away from its fixed offset after the bus rises. A wait state that does not honour the bus level shows up as a `sample_stb` during a stretched hold, or as a high count that ignores another device pulling the line low. Either error appears within SYNC_STAGES+1 cycles of the bus event. A strobe emitted from the wrong transition differs from the edge of `scl_drive_low` in that same cycle.

// File: rtl/scl_sync_pkg.sv
package scl_sync_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_WAIT = 2'd2,
    PH_HIGH = 2'd3
  } scl_phase_e;

endpackage

// File: rtl/scl_sync_chain.sv
module scl_sync_chain #(
  parameter int  STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] ff;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) ff[s] <= RESET_VAL;
          else        ff[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) ff[s] <= RESET_VAL;
          else        ff[s] <= ff[s-1];
        end
      end
    end
  endgenerate

  assign q = ff[STAGES-1];

endmodule

// File: rtl/scl_phase_cnt.sv
module scl_phase_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt,
  output logic             last
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (load) cnt <= load_val;
    else if (dec)  cnt <= cnt - ONE;
  end

  assign last = (cnt <= ONE);

  // a decrement is only requested while more than one cycle remains
  AST_CNT_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> !last) else $error("phase counter decremented past its end"); // R2

  // a freshly loaded count never starts at zero
  AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clr) |=> cnt != '0) else $error("phase counter loaded with zero"); // R2

endmodule

// File: rtl/scl_clock_sync.sv
module scl_clock_sync #(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [CNT_W-1:0] low_div,
  input  logic [CNT_W-1:0] high_div,
  input  logic             scl_in,
  output logic             scl_drive_low,
  output logic             sample_stb,
  output logic             shift_stb
);

  import scl_sync_pkg::*;

  // the low phase must outlast the synchronizer so WAIT never sees a stale high
  localparam int               MIN_LOW   = SYNC_STAGES + 1;
  localparam logic [CNT_W-1:0] MIN_LOW_V = MIN_LOW[CNT_W-1:0];
  localparam logic [CNT_W-1:0] ONE       = {{(CNT_W-1){1'b0}}, 1'b1};

  scl_phase_e       phase, phase_nxt;
  logic             scl_s;
  logic             cnt_clr, cnt_load, cnt_dec, cnt_last;
  logic [CNT_W-1:0] cnt_val, cnt_load_val;
  logic [CNT_W-1:0] eff_low, eff_high;

  scl_sync_chain #(
    .STAGES    (SYNC_STAGES),
    .RESET_VAL (1'b1)
  ) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (scl_in),
    .q     (scl_s)
  );

  scl_phase_cnt #(
    .CNT_W (CNT_W)
  ) i_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (cnt_clr),
    .load     (cnt_load),
    .load_val (cnt_load_val),
    .dec      (cnt_dec),
    .cnt      (cnt_val),
    .last     (cnt_last)
  );

  assign eff_low  = (low_div < MIN_LOW_V) ? MIN_LOW_V : low_div;
  assign eff_high = (high_div == '0) ? ONE : high_div;

  always_comb begin
    phase_nxt    = phase;
    cnt_clr      = 1'b0;
    cnt_load     = 1'b0;
    cnt_dec      = 1'b0;
    cnt_load_val = eff_low;
    if (!enable) begin
      phase_nxt = PH_IDLE;
      cnt_clr   = 1'b1;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          phase_nxt = PH_LOW;
          cnt_load  = 1'b1;
        end
        PH_LOW: begin
          if (cnt_last) phase_nxt = PH_WAIT;
          else          cnt_dec   = 1'b1;
        end
        PH_WAIT: begin
          if (scl_s) begin
            phase_nxt    = PH_HIGH;
            cnt_load     = 1'b1;
            cnt_load_val = eff_high;
          end
        end
        PH_HIGH: begin
          if (!scl_s || cnt_last) begin
            phase_nxt = PH_LOW;
            cnt_load  = 1'b1;
          end else begin
            cnt_dec = 1'b1;
          end
        end
        default: phase_nxt = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase         <= PH_IDLE;
      scl_drive_low <= 1'b0;
      shift_stb     <= 1'b0;
      sample_stb    <= 1'b0;
    end else begin
      phase         <= phase_nxt;
      scl_drive_low <= (phase_nxt == PH_LOW);
      shift_stb     <= (phase_nxt == PH_LOW)  && (phase != PH_LOW);
      sample_stb    <= (phase_nxt == PH_HIGH) && (phase != PH_HIGH);
    end
  end

  AST_OFF_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!scl_drive_low && !sample_stb && !shift_stb))
    else $error("outputs active while disabled"); // R1

  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_WAIT && !scl_s) |=> (!sample_stb && !scl_drive_low))
    else $error("left wait while bus still low"); // R3

  AST_ABANDON_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_HIGH && !scl_s && enable) |=> scl_drive_low)
    else $error("high count not abandoned"); // R5

  AST_SHIFT_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_drive_low) |-> shift_stb) else $error("missing shift strobe"); // R7

  AST_SHIFT_ONLY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    shift_stb |-> (scl_drive_low && !$past(scl_drive_low)))
    else $error("stray shift strobe"); // R7

  AST_SAMPLE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> ($past(scl_s) && !scl_drive_low))
    else $error("sample strobe without bus high"); // R8

  AST_SAMPLE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> !sample_stb) else $error("sample strobe longer than one cycle"); // R8

endmodule

// File: tb/test_scl_clock_sync.sv
module test_scl_clock_sync;

  localparam int W    = 8;
  localparam int SYNC = 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         enable = 1'b0;
  logic [W-1:0] low_div = '0;
  logic [W-1:0] high_div = '0;
  logic         other_low = 1'b0;
  logic         scl_drive_low, sample_stb, shift_stb;
  logic         scl_in;

  assign scl_in = !(scl_drive_low || other_low);

  scl_clock_sync #(.CNT_W(W), .SYNC_STAGES(SYNC)) i_scl_clock_sync (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable        (enable),
    .low_div       (low_div),
    .high_div      (high_div),
    .scl_in        (scl_in),
    .scl_drive_low (scl_drive_low),
    .sample_stb    (sample_stb),
    .shift_stb     (shift_stb)
  );

  always #5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL R3 watchdog actual=%0d expected=<150000 cycles", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  // R7 monitor: shift strobe must coincide with every rise of the drive
  logic prev_drv = 1'b0;
  int   shift_err = 0;
  always @(negedge clk) begin
    if (shift_stb !== (scl_drive_low && !prev_drv)) shift_err++;
    prev_drv = scl_drive_low;
  end

  // measure one low phase and the following released period, from negedge to negedge
  task automatic measure(input int l_eff, input int stretch,
                         output int lo, output int hi, output int spos);
    lo = 0; hi = 0; spos = -1;
    while (!scl_drive_low) @(negedge clk);
    for (int k = 0; k < 5000; k++) begin
      if (stretch > 0 && k == 0) other_low = 1'b1;
      if (k == l_eff + stretch)  other_low = 1'b0;
      if (scl_drive_low) begin
        if (hi > 0) break;
        lo++;
      end else begin
        if (sample_stb && spos < 0) spos = hi;
        hi++;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    int lo, hi, spos, le, he, s, n, lows, samps;

    // reset state
    repeat (3) @(negedge clk);
    check("R1 reset drive", int'(scl_drive_low), 0);
    check("R1 reset sample", int'(sample_stb), 0);
    check("R1 reset shift", int'(shift_stb), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 disabled drive", int'(scl_drive_low), 0);

    // sweep of division counts, free bus then stretched bus
    for (int li = 0; li < 8; li++) begin
      for (int hv = 0; hv < 7; hv++) begin
        enable = 1'b0;
        low_div = W'(li);
        high_div = W'(hv);
        repeat (2) @(negedge clk);
        enable = 1'b1;
        le = (li < SYNC + 1) ? SYNC + 1 : li;
        he = (hv < 1) ? 1 : hv;
        measure(le, 0, lo, hi, spos);
        check("R2 low length", lo, le);
        check("R4 released length", hi, he + SYNC + 1);
        check("R8 sample position", spos, SYNC + 1);
        s = (li + hv) % 5;
        measure(le, s, lo, hi, spos);
        check("R2 low length stretched", lo, le);
        check("R6 stretched released length", hi, s + SYNC + 1 + he);
        check("R8 sample position stretched", spos, s + SYNC + 1);
      end
    end

    // R3 indefinite hold by a slave
    enable = 1'b0;
    low_div = 8'd4;
    high_div = 8'd2;
    repeat (2) @(negedge clk);
    enable = 1'b1;
    while (!scl_drive_low) @(negedge clk);
    other_low = 1'b1;
    lows = 0; samps = 0;
    repeat (3000) begin
      @(negedge clk);
      if (scl_drive_low) lows++;
      if (sample_stb) samps++;
    end
    check("R3 no sample during hold", samps, 0);
    check("R3 drive only for own low count", lows, 3);
    other_low = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (!sample_stb && n < 50);
    check("R4 sample after release", n, SYNC + 1);

    // R5 another master cuts the high phase short
    low_div = 8'd4;
    high_div = 8'd9;
    do @(negedge clk); while (!sample_stb);
    @(negedge clk);
    other_low = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!scl_drive_low && n < 50);
    check("R5 abandon delay", n, SYNC + 1);
    check("R7 shift on abandon", int'(shift_stb), 1);
    other_low = 1'b0;

    // R1 disable mid low phase, then full low phase after re-enable
    low_div = 8'd5;
    high_div = 8'd3;
    while (!scl_drive_low) @(negedge clk);
    repeat (2) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check("R1 disable drive", int'(scl_drive_low), 0);
    check("R1 disable strobes", int'(sample_stb) + int'(shift_stb), 0);
    other_low = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 disabled ignores bus", int'(scl_drive_low), 0);
    other_low = 1'b0;
    repeat (4) @(negedge clk);
    enable = 1'b1;
    measure(5, 0, lo, hi, spos);
    check("R1 full low after re-enable", lo, 5);
    check("R4 released after re-enable", hi, 3 + SYNC + 1);

    check("R7 shift strobe coincidence", shift_err, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule